// File: doc/BRIEF.md
# Byte-Serial MOV Instruction Decoder

This block turns a stream of 16-bit real-mode MOV machine code into decoded instruction records. Bytes arrive one per accepted handshake. The parser walks through the opcode byte, the optional addressing byte, the displacement bytes and the immediate bytes. When the last byte of an instruction has been taken, it emits a single record. The record gives the operation class, the operand size, the register-side selector, the register-or-memory selector, the memory addressing combination, a 16-bit displacement, a 16-bit immediate and the instruction length in bytes.

The only input flow is the byte stream. It uses valid/ready. A byte transfers on a rising edge at which both `in_valid` and `in_ready` are high. The upstream side may drop `in_valid` on any cycle, and the parser holds its state while it does. The decoder never stalls in normal operation: `in_ready` is low only while `rst` is high. The output is a plain one-cycle pulse without back-pressure, so the consumer must take the record in the cycle `out_valid` is high.

An opcode outside the MOV subset is reported as an illegal one-byte instruction. A bad register field in the addressing byte is reported as an illegal two-byte instruction. In both cases the next byte is treated as a fresh opcode.

Top module: `mov_stream_decoder`

## Requirements
- R1: While `rst` is high at a clock edge, the parser returns to opcode fetch and `out_valid` goes low. `in_ready` is low while `rst` is high and high otherwise.
- R2: A byte is consumed only on an edge where `in_valid` and `in_ready` are both high. Idle cycles leave the parser unchanged, whatever is on `in_byte`. `out_valid` is high for exactly the one cycle that follows the edge at which the final byte of an instruction was taken, and it is low while an instruction is still incomplete.
- R3: `out_class` is coded as follows: 0 illegal; 1 for 88/89 (register into r/m); 2 for 8A/8B (r/m into register); 3 for 8C (segment into r/m); 4 for 8E (r/m into segment); 5 for A0/A1 (direct memory into accumulator); 6 for A2/A3 (accumulator into direct memory); 7 for B0–BF (immediate into register); 8 for C6/C7 (immediate into r/m).
- R4: `out_word` equals opcode bit 0 for 88–8B, A0–A3 and C6/C7. It equals opcode bit 3 for B0–BF. It is 1 for 8C and 8E.
- R5: For opcodes that take an addressing byte, the byte's bits 5..3 go to `out_reg` and its bits 2..0 go to `out_rm`. When bits 7..6 are 11, `out_rm_reg`=1, `out_ea`=9 (no memory) and no displacement is read.
- R6: When bits 7..6 are 00 and bits 2..0 are not 110, no displacement is read and `out_ea` is the r/m code. The codes are 0 BX+SI, 1 BX+DI, 2 BP+SI, 3 BP+DI, 4 SI, 5 DI, 6 BP, 7 BX. When bits 7..6 are 00 and r/m is 110, two address bytes follow low byte first, `out_ea`=8 (direct) and no base register is implied.
- R7: When bits 7..6 are 01, one displacement byte follows and is sign-extended to 16 bits. When they are 10, two displacement bytes follow, low byte first. In both cases `out_ea` is the r/m code.
- R8: For B0–BF, `out_reg` is the opcode's low three bits. A byte immediate follows (zero-extended into `out_imm`), or a word immediate follows low byte first.
- R9: A0–A3 take no addressing byte. Two address bytes follow, low byte first, into `out_disp`. `out_ea`=8, `out_reg`=0 (accumulator) and the length is 3.
- R10: C6/C7 need an addressing-byte reg field of 0. Any displacement comes first and the immediate last. The immediate is one byte zero-extended for C6, or a little-endian word for C7.
- R11: For 8C/8E, `out_reg` carries the segment number (0 ES, 1 CS, 2 SS, 3 DS). A reg field of 4–7 is illegal.
- R12: An opcode outside R3's list yields a record with `out_illegal`=1, `out_class`=0 and `out_len`=1. A bad reg field under R10/R11 yields `out_illegal`=1, `out_class`=0 and `out_len`=2. The following byte is parsed as an opcode.
- R13: `out_len` equals the number of bytes the instruction consumed, from 1 to 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Upstream offers a byte |
| in_ready | output | 1 | Decoder can take a byte |
| in_byte | input | 8 | Machine-code byte |
| out_valid | output | 1 | One-cycle record strobe |
| out_illegal | output | 1 | Instruction not decodable |
| out_class | output | 4 | Operation class (R3) |
| out_word | output | 1 | 1 = 16-bit operands |
| out_reg | output | 3 | Register-side selector |
| out_rm_reg | output | 1 | r/m names a register |
| out_rm | output | 3 | r/m field |
| out_ea | output | 4 | Addressing combination, 8 direct, 9 none |
| out_disp | output | 16 | Displacement or direct address |
| out_imm | output | 16 | Immediate value |
| out_len | output | 3 | Instruction length in bytes |

## Verification
The assertions assume that reset is applied synchronously for at least one edge. They also assume `in_valid` is never unknown after reset, and they only give the record fields meaning on cycles where `out_valid` is high. The stimulus holds `in_valid` low throughout reset. It then drives every opcode value and every addressing byte for the opcodes that take one. About one byte in five is preceded by an idle cycle that carries a junk byte, so the hold rule is exercised. Displacement and immediate bytes are derived from the addressing byte, so sign extension is covered for both polarities.

// File: rtl/movdec_pkg.sv
package movdec_pkg;
  localparam int BYTE_W = 8;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int SEL_W  = 3;
  localparam int CLS_W  = 4;
  localparam int EA_W   = 4;
  localparam int LEN_W  = 3;
  localparam int CNT_W  = 2;

  typedef enum logic [CLS_W-1:0] {
    CLS_ILLEGAL      = 4'd0,
    CLS_RM_FROM_REG  = 4'd1,
    CLS_REG_FROM_RM  = 4'd2,
    CLS_RM_FROM_SEG  = 4'd3,
    CLS_SEG_FROM_RM  = 4'd4,
    CLS_ACC_FROM_MEM = 4'd5,
    CLS_MEM_FROM_ACC = 4'd6,
    CLS_REG_FROM_IMM = 4'd7,
    CLS_RM_FROM_IMM  = 4'd8
  } cls_e;

  typedef enum logic [EA_W-1:0] {
    EA_BX_SI  = 4'd0,
    EA_BX_DI  = 4'd1,
    EA_BP_SI  = 4'd2,
    EA_BP_DI  = 4'd3,
    EA_SI     = 4'd4,
    EA_DI     = 4'd5,
    EA_BP     = 4'd6,
    EA_BX     = 4'd7,
    EA_DIRECT = 4'd8,
    EA_NONE   = 4'd9
  } ea_e;

  typedef enum logic [2:0] {
    ST_OPC, ST_MODRM, ST_DLO, ST_DHI, ST_ILO, ST_IHI
  } st_e;

  typedef struct packed {
    logic              illegal;
    cls_e              cls;
    logic              word;
    logic [SEL_W-1:0]  reg_sel;
    logic              rm_reg;
    logic [SEL_W-1:0]  rm;
    ea_e               ea;
    logic [WORD_W-1:0] disp;
    logic [WORD_W-1:0] imm;
    logic [LEN_W-1:0]  len;
  } rec_t;
endpackage

// File: rtl/movdec_opclass.sv
module movdec_opclass
  import movdec_pkg::*;
(
  input  logic [BYTE_W-1:0] opc,
  output logic              legal,
  output cls_e              cls,
  output logic              word,
  output logic              has_modrm,
  output logic              direct,
  output logic [CNT_W-1:0]  imm_bytes,
  output logic              reg_from_op,
  output logic [SEL_W-1:0]  reg_in_op
);
  always_comb begin
    legal       = 1'b1;
    cls         = CLS_ILLEGAL;
    word        = 1'b0;
    has_modrm   = 1'b0;
    direct      = 1'b0;
    imm_bytes   = '0;
    reg_from_op = 1'b0;
    reg_in_op   = opc[SEL_W-1:0];
    casez (opc)
      8'b1000_10??: begin
        cls       = opc[1] ? CLS_REG_FROM_RM : CLS_RM_FROM_REG;
        word      = opc[0];
        has_modrm = 1'b1;
      end
      8'b1000_1100: begin
        cls       = CLS_RM_FROM_SEG;
        word      = 1'b1;
        has_modrm = 1'b1;
      end
      8'b1000_1110: begin
        cls       = CLS_SEG_FROM_RM;
        word      = 1'b1;
        has_modrm = 1'b1;
      end
      8'b1010_00??: begin
        cls    = opc[1] ? CLS_MEM_FROM_ACC : CLS_ACC_FROM_MEM;
        word   = opc[0];
        direct = 1'b1;
      end
      8'b1011_????: begin
        cls         = CLS_REG_FROM_IMM;
        word        = opc[3];
        imm_bytes   = opc[3] ? 2'd2 : 2'd1;
        reg_from_op = 1'b1;
      end
      8'b1100_011?: begin
        cls       = CLS_RM_FROM_IMM;
        word      = opc[0];
        has_modrm = 1'b1;
        imm_bytes = opc[0] ? 2'd2 : 2'd1;
      end
      default: legal = 1'b0;
    endcase
  end
endmodule

// File: rtl/movdec_modrm.sv
module movdec_modrm
  import movdec_pkg::*;
(
  input  logic [BYTE_W-1:0] modrm,
  input  cls_e              cls,
  output ea_e               ea,
  output logic [CNT_W-1:0]  disp_bytes,
  output logic              rm_reg,
  output logic              reg_ok
);
  logic [1:0]       mode;
  logic [SEL_W-1:0] regf;
  logic [SEL_W-1:0] rmf;

  assign mode = modrm[7:6];
  assign regf = modrm[5:3];
  assign rmf  = modrm[2:0];

  always_comb begin
    rm_reg     = 1'b0;
    disp_bytes = '0;
    ea         = ea_e'({1'b0, rmf});
    unique case (mode)
      2'b00: begin
        if (rmf == 3'b110) begin
          ea         = EA_DIRECT;
          disp_bytes = 2'd2;
        end
      end
      2'b01: disp_bytes = 2'd1;
      2'b10: disp_bytes = 2'd2;
      default: begin
        rm_reg = 1'b1;
        ea     = EA_NONE;
      end
    endcase
  end

  always_comb begin
    unique case (cls)
      CLS_RM_FROM_IMM:                  reg_ok = (regf == '0);
      CLS_RM_FROM_SEG, CLS_SEG_FROM_RM: reg_ok = ~regf[2];
      default:                          reg_ok = 1'b1;
    endcase
  end
endmodule

// File: rtl/mov_stream_decoder.sv
module mov_stream_decoder
  import movdec_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_byte,
  output logic              out_valid,
  output logic              out_illegal,
  output logic [3:0]        out_class,
  output logic              out_word,
  output logic [2:0]        out_reg,
  output logic              out_rm_reg,
  output logic [2:0]        out_rm,
  output logic [3:0]        out_ea,
  output logic [15:0]       out_disp,
  output logic [15:0]       out_imm,
  output logic [2:0]        out_len
);
  st_e              st_q, st_d;
  rec_t             cur_q, cur_d, out_q;
  logic [CNT_W-1:0] dsp_q, dsp_d, imm_q, imm_d;
  logic             out_v_q;
  logic             take, done;

  logic             oc_legal, oc_word, oc_modrm, oc_direct, oc_reg_from_op;
  cls_e             oc_cls;
  logic [CNT_W-1:0] oc_imm;
  logic [SEL_W-1:0] oc_reg;

  ea_e              mr_ea;
  logic [CNT_W-1:0] mr_disp;
  logic             mr_rm_reg, mr_reg_ok;

  movdec_opclass u_opclass (
    .opc         (in_byte),
    .legal       (oc_legal),
    .cls         (oc_cls),
    .word        (oc_word),
    .has_modrm   (oc_modrm),
    .direct      (oc_direct),
    .imm_bytes   (oc_imm),
    .reg_from_op (oc_reg_from_op),
    .reg_in_op   (oc_reg)
  );

  movdec_modrm u_modrm (
    .modrm      (in_byte),
    .cls        (cur_q.cls),
    .ea         (mr_ea),
    .disp_bytes (mr_disp),
    .rm_reg     (mr_rm_reg),
    .reg_ok     (mr_reg_ok)
  );

  assign in_ready = ~rst;
  assign take     = in_valid & in_ready;

  always_comb begin
    st_d  = st_q;
    cur_d = cur_q;
    dsp_d = dsp_q;
    imm_d = imm_q;
    done  = 1'b0;
    if (take) begin
      cur_d.len = cur_q.len + 1'b1;
      unique case (st_q)
        ST_OPC: begin
          cur_d         = '0;
          cur_d.ea      = EA_NONE;
          cur_d.len     = 3'd1;
          cur_d.cls     = oc_cls;
          cur_d.word    = oc_word;
          cur_d.reg_sel = oc_reg_from_op ? oc_reg : '0;
          imm_d         = oc_imm;
          dsp_d         = oc_direct ? 2'd2 : 2'd0;
          if (!oc_legal) begin
            cur_d.illegal = 1'b1;
            done          = 1'b1;
          end else if (oc_modrm) begin
            st_d = ST_MODRM;
          end else if (oc_direct) begin
            cur_d.ea = EA_DIRECT;
            st_d     = ST_DLO;
          end else begin
            st_d = ST_ILO;
          end
        end
        ST_MODRM: begin
          cur_d.reg_sel = in_byte[5:3];
          cur_d.rm      = in_byte[2:0];
          cur_d.rm_reg  = mr_rm_reg;
          cur_d.ea      = mr_ea;
          dsp_d         = mr_disp;
          if (!mr_reg_ok) begin
            cur_d.illegal = 1'b1;
            cur_d.cls     = CLS_ILLEGAL;
            done          = 1'b1;
          end else if (mr_disp != '0) begin
            st_d = ST_DLO;
          end else if (imm_q != '0) begin
            st_d = ST_ILO;
          end else begin
            done = 1'b1;
          end
        end
        ST_DLO: begin
          cur_d.disp = (dsp_q == 2'd1) ? {{BYTE_W{in_byte[7]}}, in_byte}
                                       : {{BYTE_W{1'b0}}, in_byte};
          if (dsp_q == 2'd2)       st_d = ST_DHI;
          else if (imm_q != '0)    st_d = ST_ILO;
          else                     done = 1'b1;
        end
        ST_DHI: begin
          cur_d.disp[WORD_W-1:BYTE_W] = in_byte;
          if (imm_q != '0) st_d = ST_ILO;
          else             done = 1'b1;
        end
        ST_ILO: begin
          cur_d.imm = {{BYTE_W{1'b0}}, in_byte};
          if (imm_q == 2'd2) st_d = ST_IHI;
          else               done = 1'b1;
        end
        ST_IHI: begin
          cur_d.imm[WORD_W-1:BYTE_W] = in_byte;
          done = 1'b1;
        end
        default: st_d = ST_OPC;
      endcase
      if (done) st_d = ST_OPC;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= ST_OPC;
      cur_q   <= '0;
      dsp_q   <= '0;
      imm_q   <= '0;
      out_v_q <= 1'b0;
      out_q   <= '0;
    end else begin
      st_q    <= st_d;
      cur_q   <= cur_d;
      dsp_q   <= dsp_d;
      imm_q   <= imm_d;
      out_v_q <= done;
      if (done) out_q <= cur_d;
    end
  end

  assign out_valid   = out_v_q;
  assign out_illegal = out_q.illegal;
  assign out_class   = out_q.cls;
  assign out_word    = out_q.word;
  assign out_reg     = out_q.reg_sel;
  assign out_rm_reg  = out_q.rm_reg;
  assign out_rm      = out_q.rm;
  assign out_ea      = out_q.ea;
  assign out_disp    = out_q.disp;
  assign out_imm     = out_q.imm;
  assign out_len     = out_q.len;
endmodule

// File: rtl/movdec_checker.sv
module movdec_checker (
  input logic        clk,
  input logic        rst,
  input logic        in_valid,
  input logic        in_ready,
  input logic        out_valid,
  input logic        out_illegal,
  input logic [3:0]  out_class,
  input logic        out_word,
  input logic [2:0]  out_reg,
  input logic        out_rm_reg,
  input logic [3:0]  out_ea,
  input logic [15:0] out_disp,
  input logic [7:0]  imm_hi,
  input logic [2:0]  out_len
);
  AST_PULSE_NEEDS_BYTE: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> $past(in_valid && in_ready)); // R2

  AST_ILLEGAL_SHAPE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_illegal) |-> (out_class == 4'd0 && (out_len == 3'd1 || out_len == 3'd2))); // R12

  AST_LEN_BOUND: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (out_len >= 3'd1 && out_len <= 3'd6)); // R13

  AST_REG_FORM_NO_DISP: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_illegal && out_rm_reg) |-> (out_ea == 4'd9 && out_disp == 16'h0000)); // R5

  AST_REGIMM_SHAPE: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_illegal && out_class == 4'd7)
      |-> (out_len == (out_word ? 3'd3 : 3'd2) && (out_word || imm_hi == 8'h00))); // R8

  AST_ACC_DIRECT: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_illegal && (out_class == 4'd5 || out_class == 4'd6))
      |-> (out_ea == 4'd8 && out_len == 3'd3 && out_reg == 3'd0)); // R9
endmodule

bind mov_stream_decoder movdec_checker u_chk (
  .clk         (clk),
  .rst         (rst),
  .in_valid    (in_valid),
  .in_ready    (in_ready),
  .out_valid   (out_valid),
  .out_illegal (out_illegal),
  .out_class   (out_class),
  .out_word    (out_word),
  .out_reg     (out_reg),
  .out_rm_reg  (out_rm_reg),
  .out_ea      (out_ea),
  .out_disp    (out_disp),
  .imm_hi      (out_imm[15:8]),
  .out_len     (out_len)
);

// File: tb/mov_stream_decoder_tb.sv
module mov_stream_decoder_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic [7:0]  in_byte = 8'h00;
  logic        in_ready, out_valid, out_illegal, out_word, out_rm_reg;
  logic [3:0]  out_class, out_ea;
  logic [2:0]  out_reg, out_rm, out_len;
  logic [15:0] out_disp, out_imm;

  int n_checks = 0;
  int n_errors = 0;
  int gap_ctr  = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  mov_stream_decoder u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready), .in_byte(in_byte),
    .out_valid(out_valid), .out_illegal(out_illegal), .out_class(out_class),
    .out_word(out_word), .out_reg(out_reg), .out_rm_reg(out_rm_reg), .out_rm(out_rm),
    .out_ea(out_ea), .out_disp(out_disp), .out_imm(out_imm), .out_len(out_len)
  );

  function automatic logic [51:0] pack_rec(input logic ill, input logic [3:0] cls,
      input logic w, input logic [2:0] rg, input logic rr, input logic [2:0] rm,
      input logic [3:0] ea, input logic [15:0] d, input logic [15:0] im, input logic [2:0] ln);
    return {ill, cls, w, rg, rr, rm, ea, d, im, ln};
  endfunction

  localparam logic [51:0] ILL_MASK = {1'b1, 4'hF, 44'h0, 3'h7};

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Expected record from the requirement text; displacement/immediate bytes derived from m.
  task automatic build(input logic [7:0] op, input logic [7:0] m,
                       output logic [47:0] bv, output int n,
                       output logic [51:0] exp, output bit ill_only, output string req);
    int cls, w, rg, rr, rm, ea, nd, ni, md;
    bit ill, hasm;
    int disp, imm;
    logic [7:0] d0, d1, i0, i1;
    d0 = m ^ 8'h5A; d1 = m + 8'd3; i0 = ~m; i1 = m ^ 8'hC3;
    bv = '0; n = 0; ill = 0; hasm = 0;
    cls = 0; w = 0; rg = 0; rr = 0; rm = 0; ea = 9; nd = 0; ni = 0; disp = 0; imm = 0;
    req = "";
    bv[8*n +: 8] = op; n++;
    if (op >= 8'h88 && op <= 8'h8B) begin
      cls = (op >= 8'h8A) ? 2 : 1; w = op % 2; hasm = 1; req = "R3 R4";
    end else if (op == 8'h8C || op == 8'h8E) begin
      cls = (op == 8'h8C) ? 3 : 4; w = 1; hasm = 1; req = "R11 R4";
    end else if (op >= 8'hA0 && op <= 8'hA3) begin
      cls = (op >= 8'hA2) ? 6 : 5; w = op % 2; nd = 2; ea = 8; req = "R9 R3";
    end else if (op >= 8'hB0 && op <= 8'hBF) begin
      cls = 7; w = (op >= 8'hB8) ? 1 : 0; rg = op - (w ? 8'hB8 : 8'hB0);
      ni = w + 1; req = "R8 R4";
    end else if (op == 8'hC6 || op == 8'hC7) begin
      cls = 8; w = op - 8'hC6; hasm = 1; ni = w + 1; req = "R10 R4";
    end else begin
      ill = 1; req = "R12";
    end
    if (hasm) begin
      bv[8*n +: 8] = m; n++;
      rg = (m / 8) % 8; rm = m % 8; md = m / 64;
      if ((cls == 8 && rg != 0) || ((cls == 3 || cls == 4) && rg >= 4)) begin
        ill = 1; cls = 0; req = "R12";
      end else if (md == 3) begin
        rr = 1; ea = 9; req = {req, " R5"};
      end else if (md == 0 && rm == 6) begin
        ea = 8; nd = 2; req = {req, " R6"};
      end else begin
        ea = rm; nd = md; req = {req, (md == 0) ? " R6" : " R7"};
      end
    end
    if (!ill) begin
      if (nd >= 1) begin bv[8*n +: 8] = d0; n++; end
      if (nd == 2) begin bv[8*n +: 8] = d1; n++; end
      if (nd == 1) disp = (d0 >= 128) ? (int'(d0) + 16'hFF00) : int'(d0);
      if (nd == 2) disp = int'(d1) * 256 + int'(d0);
      if (ni >= 1) begin bv[8*n +: 8] = i0; n++; end
      if (ni == 2) begin bv[8*n +: 8] = i1; n++; end
      imm = (ni == 2) ? int'(i1) * 256 + int'(i0) : (ni == 1 ? int'(i0) : 0);
    end
    req = {req, " R13"};
    ill_only = ill;
    exp = pack_rec(ill, 4'(cls), w[0], 3'(rg), rr[0], 3'(rm), 4'(ea), 16'(disp), 16'(imm), 3'(n));
  endtask

  task automatic run_instr(input logic [47:0] bv, input int n,
                           input logic [51:0] exp, input bit ill_only, input string req);
    logic [51:0] act;
    for (int i = 0; i < n; i++) begin
      if (gap_ctr % 5 == 4) begin
        @(negedge clk); in_valid = 1'b0; in_byte = 8'hFF;
        @(posedge clk);
      end
      gap_ctr++;
      @(negedge clk);
      if (i > 0) check(out_valid == 1'b0, "R2", "pulse before final byte", 64'(out_valid), 64'd0);
      in_valid = 1'b1; in_byte = bv[8*i +: 8];
      @(posedge clk);
    end
    @(negedge clk);
    in_valid = 1'b0;
    check(out_valid == 1'b1, "R2", "record strobe after final byte", 64'(out_valid), 64'd1);
    act = pack_rec(out_illegal, out_class, out_word, out_reg, out_rm_reg, out_rm,
                   out_ea, out_disp, out_imm, out_len);
    if (ill_only) check((act & ILL_MASK) == (exp & ILL_MASK), req, "illegal record",
                        64'(act & ILL_MASK), 64'(exp & ILL_MASK));
    else check(act == exp, req, $sformatf("record for opcode %h", bv[7:0]), 64'(act), 64'(exp));
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++; n_errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [47:0] bv;
    int n;
    logic [51:0] exp;
    bit ill_only;
    string req;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(in_ready == 1'b0, "R1", "ready during reset", 64'(in_ready), 64'd0);
    check(out_valid == 1'b0, "R1", "strobe during reset", 64'(out_valid), 64'd0);
    rst = 1'b0;
    @(negedge clk);
    check(in_ready == 1'b1, "R1", "ready after reset", 64'(in_ready), 64'd1);
    check(out_valid == 1'b0, "R1", "strobe after reset", 64'(out_valid), 64'd0);
    // R2: idle cycles with junk bytes must not start an instruction.
    in_byte = 8'h8B;
    repeat (4) @(negedge clk);
    check(out_valid == 1'b0, "R2", "idle junk ignored", 64'(out_valid), 64'd0);

    for (int op = 0; op < 256; op++) begin
      if ((op >= 8'h88 && op <= 8'h8C) || op == 8'h8E || op == 8'hC6 || op == 8'hC7) begin
        for (int m = 0; m < 256; m++) begin
          build(8'(op), 8'(m), bv, n, exp, ill_only, req);
          run_instr(bv, n, exp, ill_only, req);
        end
      end else begin
        build(8'(op), 8'(op ^ 8'h37), bv, n, exp, ill_only, req);
        run_instr(bv, n, exp, ill_only, req);
      end
    end

    // R1: reset mid-instruction returns to opcode fetch.
    @(negedge clk); in_valid = 1'b1; in_byte = 8'hC7;
    @(negedge clk); in_byte = 8'h80;
    @(negedge clk); in_valid = 1'b0; rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    build(8'hB1, 8'h00, bv, n, exp, ill_only, req);
    run_instr(bv, n, exp, ill_only, {"R1 ", req});
    finish_run();
  end
endmodule